// File: doc/BRIEF.md
# Phase-Accumulator Pin Counter

One counter channel that drives a general-purpose output pin from the top bit of a 32-bit phase accumulator. In oscillator mode, the block adds a frequency word to the accumulator on every system clock. The accumulator's most significant bit becomes a square wave whose frequency is `clk * freq / 2^32`. This gives fine-grained frequency synthesis with a single adder.

Software can also overwrite the accumulator at any time. A write takes effect at the next clock edge and takes precedence over that cycle's addition. With a zero frequency word, each write therefore places one data bit on the pin, and the same counter works as a direct-write serial data output. A phase-locked multiplier mode code is recognised and reported on a flag, but it drives nothing. Any code other than the oscillator code leaves the accumulator frozen and the pin low.

Top module: `pin_phase_counter`

## Requirements
- R1: While `rst_n` is low, the accumulator and the frequency word are cleared, and `pin_o` is low from the first clock edge after reset.
- R2: With `mode_i` = 5'b00100 (oscillator) and no phase write, every rising clock edge replaces the accumulator with accumulator + frequency word, modulo 2^32.
- R3: `pin_o` is a register loaded at the same edge as the accumulator. In oscillator mode it equals bit 31 of the new accumulator value.
- R4: With a frequency word of 2^27 and an accumulator starting at 0, the pin is low for 16 clocks and then high for 16 clocks (clock divided by 32).
- R5: A phase write (`phs_we` high) loads `phs_wdata` at the next edge, and the addition for that cycle is skipped. In oscillator mode the pin takes bit 31 of the written value at that same edge.
- R6: With `mode_i` = 0 and no phase write, the accumulator holds its value and `pin_o` is low after the edge.
- R7: With `mode_i` = 5'b00010 (multiplier mode), `pll_sel_o` is high, the accumulator holds, and `pin_o` is low after the edge.
- R8: Any other mode code behaves like mode 0 (hold, pin low), with `pll_sel_o` low.
- R9: `pin_oe` follows `dir_i` combinationally, whatever the mode.
- R10: `phs_rdata` always shows the current accumulator value. Reading has no side effects, so it stays constant while the accumulator holds.
- R11: A frequency write (`frq_we`) loads `frq_wdata` at the next edge. An addition in that same cycle still uses the old frequency word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Mode code (00100 oscillator, 00010 multiplier, others off) |
| dir_i | input | 1 | Direction bit driving the output enable |
| frq_we | input | 1 | Frequency word write strobe |
| frq_wdata | input | 32 | Frequency word write data |
| phs_we | input | 1 | Accumulator write strobe |
| phs_wdata | input | 32 | Accumulator write data |
| phs_rdata | output | 32 | Current accumulator value |
| pin_o | output | 1 | Registered pin level |
| pin_oe | output | 1 | Pin output enable |
| pll_sel_o | output | 1 | Multiplier mode selected (not implemented) |

## Verification
The assertions check on every cycle that:
- the accumulator steps by exactly the frequency word in oscillator mode;
- a phase write wins over the addition;
- the accumulator freezes when the block is disabled;
- the pin is low outside oscillator mode and tracks the accumulator's top bit inside it.

Some behaviour only the bench's scenarios can show:
- the divide-by-32 waveform timing for a frequency word of 2^27;
- the modulo wrap of the accumulator;
- that a frequency write in the same cycle still adds with the old word;
- the bit-by-bit serial output produced by successive phase writes.

// File: rtl/pin_phase_counter.sv
module pin_phase_counter #(
  parameter int PHASE_W = 32,
  parameter int MODE_W  = 5,
  parameter logic [MODE_W-1:0] NCO_CODE = 5'b00100,
  parameter logic [MODE_W-1:0] PLL_CODE = 5'b00010
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic               dir_i,
  input  logic               frq_we,
  input  logic [PHASE_W-1:0] frq_wdata,
  input  logic               phs_we,
  input  logic [PHASE_W-1:0] phs_wdata,
  output logic [PHASE_W-1:0] phs_rdata,
  output logic               pin_o,
  output logic               pin_oe,
  output logic               pll_sel_o
);
  localparam int MSB = PHASE_W - 1;

  logic [PHASE_W-1:0] frq_q, phs_q, phs_d;
  logic               pin_q;
  logic               nco_on;

  assign nco_on = (mode_i == NCO_CODE);

  always_comb begin
    if (phs_we)      phs_d = phs_wdata;
    else if (nco_on) phs_d = phs_q + frq_q;
    else             phs_d = phs_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frq_q <= '0;
      phs_q <= '0;
      pin_q <= 1'b0;
    end else begin
      if (frq_we) frq_q <= frq_wdata;
      phs_q <= phs_d;
      pin_q <= nco_on & phs_d[MSB];
    end
  end

  assign phs_rdata = phs_q;
  assign pin_o     = pin_q;
  assign pin_oe    = dir_i;
  assign pll_sel_o = (mode_i == PLL_CODE);
endmodule

// File: rtl/pin_phase_counter_chk.sv
module pin_phase_counter_chk #(
  parameter int PHASE_W = 32,
  parameter int MODE_W  = 5,
  parameter logic [MODE_W-1:0] NCO_CODE = 5'b00100,
  parameter logic [MODE_W-1:0] PLL_CODE = 5'b00010
) (
  input logic               clk,
  input logic               rst_n,
  input logic [MODE_W-1:0]  mode_i,
  input logic               phs_we,
  input logic [PHASE_W-1:0] phs_wdata,
  input logic [PHASE_W-1:0] frq_q,
  input logic [PHASE_W-1:0] phs_rdata,
  input logic               pin_o,
  input logic               pll_sel_o
);
  AST_NCO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == NCO_CODE && !phs_we) |=> phs_rdata == $past(phs_rdata + frq_q)); // R2
  AST_PIN_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == NCO_CODE) |=> pin_o == phs_rdata[PHASE_W-1]); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    phs_we |=> phs_rdata == $past(phs_wdata)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != NCO_CODE && !phs_we) |=> $stable(phs_rdata)); // R6
  AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != NCO_CODE) |=> !pin_o); // R8
  AST_PLL_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    pll_sel_o |=> !pin_o); // R7
endmodule

bind pin_phase_counter pin_phase_counter_chk #(
  .PHASE_W(PHASE_W), .MODE_W(MODE_W), .NCO_CODE(NCO_CODE), .PLL_CODE(PLL_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .phs_we(phs_we),
  .phs_wdata(phs_wdata), .frq_q(frq_q), .phs_rdata(phs_rdata),
  .pin_o(pin_o), .pll_sel_o(pll_sel_o)
);

// File: tb/tb_pin_phase_counter.sv
module tb_pin_phase_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = '0;
  logic        dir_i = 1'b0;
  logic        frq_we = 1'b0;
  logic [31:0] frq_wdata = '0;
  logic        phs_we = 1'b0;
  logic [31:0] phs_wdata = '0;
  logic [31:0] phs_rdata;
  logic        pin_o, pin_oe, pll_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pin_phase_counter dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
    .frq_we(frq_we), .frq_wdata(frq_wdata), .phs_we(phs_we),
    .phs_wdata(phs_wdata), .phs_rdata(phs_rdata), .pin_o(pin_o),
    .pin_oe(pin_oe), .pll_sel_o(pll_sel_o)
  );

  typedef struct packed {
    logic [4:0]  mode;
    logic        fwe;
    logic [31:0] fdata;
    logic        pwe;
    logic [31:0] pdata;
    logic [31:0] ephs;
    logic        epin;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{5'b00000, 1'b1, 32'h10,  1'b0, 32'h0,        32'h0,        1'b0},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h10,       1'b0},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h20,       1'b0},
    '{5'b00100, 1'b0, 32'h0,   1'b1, 32'h7FFFFFF8, 32'h7FFFFFF8, 1'b0},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000008, 1'b1},
    '{5'b00000, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000008, 1'b0},
    '{5'b00000, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000008, 1'b0},
    '{5'b00010, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000008, 1'b0},
    '{5'b00101, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000008, 1'b0},
    '{5'b00100, 1'b1, 32'h100, 1'b0, 32'h0,        32'h80000018, 1'b1},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000118, 1'b1},
    '{5'b00100, 1'b0, 32'h0,   1'b1, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h000000FF, 1'b0},
    '{5'b00000, 1'b0, 32'h0,   1'b1, 32'h80000000, 32'h80000000, 1'b0},
    '{5'b00100, 1'b1, 32'h0,   1'b0, 32'h0,        32'h80000100, 1'b1},
    '{5'b00100, 1'b0, 32'h0,   1'b0, 32'h0,        32'h80000100, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] m, input logic fw, input logic [31:0] fd,
                      input logic pw, input logic [31:0] pd);
    mode_i = m; frq_we = fw; frq_wdata = fd; phs_we = pw; phs_wdata = pd;
    @(negedge clk);
    frq_we = 1'b0; phs_we = 1'b0;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 phase", phs_rdata, 32'h0);
    check("R1 pin", {31'b0, pin_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].mode, VEC[i].fwe, VEC[i].fdata, VEC[i].pwe, VEC[i].pdata);
      check($sformatf("vec%0d R2/R3/R5/R6/R7/R8/R11 phase", i), phs_rdata, VEC[i].ephs);
      check($sformatf("vec%0d R3/R6/R7/R8 pin", i), {31'b0, pin_o}, {31'b0, VEC[i].epin});
    end

    // R4: divide by 32
    step(5'b00100, 1'b1, 32'h08000000, 1'b1, 32'h0);
    check("R4 start pin", {31'b0, pin_o}, 32'h0);
    for (int k = 1; k <= 48; k++) begin
      step(5'b00100, 1'b0, 32'h0, 1'b0, 32'h0);
      if (k == 15 || k == 16 || k == 31 || k == 32 || k == 48)
        check($sformatf("R4 pin at k=%0d", k), {31'b0, pin_o},
              {31'b0, (k >= 16 && k < 32) || k == 48});
    end

    // R5: bit-banged serial output with zero frequency
    step(5'b00100, 1'b1, 32'h0, 1'b1, 32'h80000000);
    check("R5 bit1", {31'b0, pin_o}, 32'h1);
    step(5'b00100, 1'b0, 32'h0, 1'b1, 32'h12345678);
    check("R5 bit0", {31'b0, pin_o}, 32'h0);
    step(5'b00100, 1'b0, 32'h0, 1'b1, 32'hC0000000);
    check("R5 bit1 again", {31'b0, pin_o}, 32'h1);
    check("R5 value", phs_rdata, 32'hC0000000);

    // R9: output enable tracks direction bit
    mode_i = 5'b00000; dir_i = 1'b1; #1;
    check("R9 oe high mode0", {31'b0, pin_oe}, 32'h1);
    mode_i = 5'b00100; dir_i = 1'b0; #1;
    check("R9 oe low nco", {31'b0, pin_oe}, 32'h0);
    dir_i = 1'b1; #1;
    check("R9 oe high nco", {31'b0, pin_oe}, 32'h1);

    // R7 / R8: flag
    mode_i = 5'b00010; #1;
    check("R7 flag", {31'b0, pll_sel_o}, 32'h1);
    mode_i = 5'b11111; #1;
    check("R8 flag low", {31'b0, pll_sel_o}, 32'h0);

    // R10: repeated reads while holding
    step(5'b00000, 1'b1, 32'h55, 1'b0, 32'h0);
    held = phs_rdata;
    for (int k = 0; k < 4; k++) begin
      step(5'b00000, 1'b0, 32'h0, 1'b0, 32'h0);
      check("R10 read stable", phs_rdata, held);
    end

    // R1: mid-run reset
    step(5'b00100, 1'b0, 32'h0, 1'b1, 32'h80000000);
    rst_n = 1'b0;
    step(5'b00100, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R1 reset phase", phs_rdata, 32'h0);
    check("R1 reset pin", {31'b0, pin_o}, 32'h0);
    rst_n = 1'b1;
    step(5'b00100, 1'b0, 32'h0, 1'b0, 32'h0);
    check("R1 frq cleared", phs_rdata, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule